// File: doc/BRIEF.md
# Code Patch and Breakpoint Comparator Unit

This block watches every access into the low code region and holds eight word-address comparators. Six are code comparators that act on instruction fetches. Two are literal comparators that act on literal-data loads. When an enabled comparator matches, the block does one of two things. It can redirect the access to one word of a remap table, which lets a fixed code image be patched from a writable table. Or it can raise a breakpoint request for the lower halfword, the upper halfword or both halfwords of the matched word.

Software sets the unit up over a simple 32-bit register bus addressed by word index. Index 0 is a control word. It holds a global enable that can only be changed by a keyed write, plus fixed read-only comparator counts. Index 1 holds the remap table base, of which only a middle slice is writable. Indices 2 to 9 hold one configuration word per comparator. The path from the access address to the outputs is combinational. Register writes take effect on the next clock edge.

Top module: `code_patch_unit`

## Requirements
- R1: After reset, index 0 reads 0x00000260, index 1 reads 0x20000000 and indices 2 to 9 read 0. No output is asserted.
- R2: A write to index 0 changes the enable (bit 0) only when bit 1 of the written data is 1. Otherwise it is discarded. Bit 1 always reads 0.
- R3: Index 0 always reports fixed values that writes cannot alter: 6 in bits 7:4, 2 in bits 11:8 and 0 in bits 13:12.
- R4: Only bits 28:5 of index 1 can be written. Bits 31:29 always read 3'b001 and bits 4:0 always read 0.
- R5: Comparator words at indices 2 to 9 read back all 32 written bits. A write to any index from 10 to 15 changes nothing, and such an index reads 0.
- R6: Comparator n matches when all of these hold: its word bit 0 is 1, the global enable is 1, access address bits 31:29 are 0, and access address bits 28:2 equal its word bits 28:2. A disabled or non-matching comparator drives no output.
- R7: Comparators 0 to 5 react only to fetches (acc_is_lit = 0). Comparators 6 and 7 react only to literal loads (acc_is_lit = 1).
- R8: A remap hit on comparator n drives remap_hit = 1 and remap_addr = {3'b001, base bits 28:5, 5'b0} + 4*n. With no remap hit, remap_addr is 0.
- R9: Mode field bits 31:30 of the matching word select the action. Mode 0 is a remap. Mode 1 sets brk_lo only, mode 2 sets brk_hi only and mode 3 sets both. Breakpoint modes never remap.
- R10: Comparators 6 and 7 always remap on a match, whatever their mode field holds.
- R11: When several comparators match one access, the lowest-numbered one alone decides the remap address and the breakpoint flags.
- R12: A register write acts on the outputs only from the clock edge that captures it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| acc_word | input | 30 | Access address bits 31:2 |
| acc_is_lit | input | 1 | 1 = literal load, 0 = instruction fetch |
| remap_hit | output | 1 | Access is redirected |
| remap_addr | output | 32 | Redirected word address |
| brk_lo | output | 1 | Breakpoint on lower halfword |
| brk_hi | output | 1 | Breakpoint on upper halfword |

## Verification
The hardest case to reach from the ports is two enabled comparators watching the same word with different actions. Here the lower-numbered one must decide the outputs both ways: its remap must suppress a breakpoint, and once it is disabled the breakpoint must appear. The bench programs comparators 0 and 4 on one word with remap and lower-halfword modes. It checks the remap, then disables comparator 0 and checks that brk_lo appears. It also programs literal comparator 7 on the same word, so that the fetch versus literal selection is shown on that word too. A mode-3 literal comparator and a keyed write landing exactly at a sampled edge cover the remaining corners.

// File: rtl/cpatch_pkg.sv
package cpatch_pkg;
    localparam int N_CODE  = 6;
    localparam int N_LIT   = 2;
    localparam int N_BANK  = 0;
    localparam int N_CMP   = N_CODE + N_LIT;
    localparam int IDX_W   = $clog2(N_CMP);
    localparam int BADDR_W = 4;
    localparam int DW      = 32;
    localparam int BASE_W  = 24;
    localparam int CMPW_W  = 27;
    localparam int IDX_CTRL  = 0;
    localparam int IDX_REMAP = 1;
    localparam int IDX_CMP0  = 2;

    typedef logic [1:0] mode_t;

    typedef struct packed {
        logic                       en;
        logic [BASE_W-1:0]          base;
        logic [N_CMP-1:0][DW-1:0]   cmp;
    } reg_state_t;
endpackage

// File: rtl/cpatch_regs.sv
module cpatch_regs
    import cpatch_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [BADDR_W-1:0]        bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic                      glob_en,
    output logic [BASE_W-1:0]         remap_base,
    output logic [N_CMP-1:0][DW-1:0]  cmp_cfg
);
    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_sel && bus_wr) begin
            if (bus_addr == BADDR_W'(IDX_CTRL)) begin
                // keyed write: bit 1 must be set
                if (bus_wdata[1]) st_d.en = bus_wdata[0];
            end
            if (bus_addr == BADDR_W'(IDX_REMAP)) begin
                st_d.base = bus_wdata[28:5];
            end
            for (int i = 0; i < N_CMP; i++) begin
                if (bus_addr == BADDR_W'(IDX_CMP0 + i)) st_d.cmp[i] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BADDR_W'(IDX_CTRL)) begin
            bus_rdata = {18'd0, 2'(N_BANK), 4'(N_LIT), 4'(N_CODE), 3'b000, st_q.en};
        end
        if (bus_addr == BADDR_W'(IDX_REMAP)) begin
            bus_rdata = {3'b001, st_q.base, 5'b00000};
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (bus_addr == BADDR_W'(IDX_CMP0 + i)) bus_rdata = st_q.cmp[i];
        end
    end

    assign glob_en    = st_q.en;
    assign remap_base = st_q.base;
    assign cmp_cfg    = st_q.cmp;
endmodule

// File: rtl/cpatch_slice.sv
module cpatch_slice
    import cpatch_pkg::*;
#(
    parameter bit IS_LIT = 1'b0
) (
    input  logic              gen_en,
    input  logic              cfg_en,
    input  mode_t             cfg_mode,
    input  logic [CMPW_W-1:0] cfg_word,
    input  logic [29:0]       acc_word,
    input  logic              acc_is_lit,
    output logic              hit,
    output mode_t             mode
);
    logic kind_ok;
    logic addr_ok;

    generate
        if (IS_LIT) begin : g_lit
            assign kind_ok = acc_is_lit;
            assign mode    = 2'b00;
        end else begin : g_code
            assign kind_ok = !acc_is_lit;
            assign mode    = cfg_mode;
        end
    endgenerate

    assign addr_ok = (acc_word[29:27] == 3'b000) && (acc_word[CMPW_W-1:0] == cfg_word);
    assign hit     = gen_en && cfg_en && kind_ok && addr_ok;
endmodule

// File: rtl/cpatch_prio.sv
module cpatch_prio
    import cpatch_pkg::*;
#(
    parameter int N  = N_CMP,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  hits,
    input  mode_t [N-1:0] modes,
    output logic          any,
    output logic [IW-1:0] idx,
    output mode_t         mode
);
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        mode = 2'b00;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any  = 1'b1;
                idx  = IW'(i);
                mode = modes[i];
            end
        end
    end
endmodule

// File: rtl/code_patch_unit.sv
module code_patch_unit
    import cpatch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [BADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [29:0]        acc_word,
    input  logic               acc_is_lit,
    output logic               remap_hit,
    output logic [DW-1:0]      remap_addr,
    output logic               brk_lo,
    output logic               brk_hi
);
    logic                     glob_en;
    logic [BASE_W-1:0]        remap_base;
    logic [N_CMP-1:0][DW-1:0] cmp_cfg;
    logic [N_CMP-1:0]         hits;
    mode_t [N_CMP-1:0]        modes;
    logic                     win_any;
    logic [IDX_W-1:0]         win_idx;
    mode_t                    win_mode;

    cpatch_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .glob_en    (glob_en),
        .remap_base (remap_base),
        .cmp_cfg    (cmp_cfg)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        cpatch_slice #(.IS_LIT(g >= N_CODE)) u_slice (
            .gen_en     (glob_en),
            .cfg_en     (cmp_cfg[g][0]),
            .cfg_mode   (cmp_cfg[g][31:30]),
            .cfg_word   (cmp_cfg[g][28:2]),
            .acc_word   (acc_word),
            .acc_is_lit (acc_is_lit),
            .hit        (hits[g]),
            .mode       (modes[g])
        );
    end

    cpatch_prio #(.N(N_CMP), .IW(IDX_W)) u_prio (
        .hits  (hits),
        .modes (modes),
        .any   (win_any),
        .idx   (win_idx),
        .mode  (win_mode)
    );

    always_comb begin
        remap_hit  = win_any && (win_mode == 2'b00);
        brk_lo     = win_any && win_mode[0];
        brk_hi     = win_any && win_mode[1];
        remap_addr = '0;
        if (remap_hit) begin
            remap_addr = {3'b001, remap_base, 5'b00000} + (DW'(win_idx) << 2);
        end
    end
endmodule

// File: rtl/cpatch_chk.sv
module cpatch_chk
    import cpatch_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [BADDR_W-1:0] bus_addr,
    input logic [DW-1:0]      bus_wdata,
    input logic               glob_en,
    input logic [29:0]        acc_word,
    input logic               remap_hit,
    input logic [DW-1:0]      remap_addr,
    input logic               brk_lo,
    input logic               brk_hi
);
    // R2
    ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'd0 && !bus_wdata[1]) |=> $stable(glob_en));

    // R12
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(glob_en));

    // R6
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (!remap_hit && !brk_lo && !brk_hi));

    // R6
    high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_word[29:27] != 3'b000) |-> (!remap_hit && !brk_lo && !brk_hi));

    // R9
    excl_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (!brk_lo && !brk_hi));

    // R8
    remap_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (remap_addr[31:29] == 3'b001 && remap_addr[1:0] == 2'b00));
endmodule

bind code_patch_unit cpatch_chk u_chk (.*);

// File: tb/code_patch_unit_bench.sv
module code_patch_unit_bench;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [29:0] acc_word = '0;
    logic        acc_is_lit = 1'b0;
    logic        remap_hit;
    logic [31:0] remap_addr;
    logic        brk_lo;
    logic        brk_hi;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    code_patch_unit u_code_patch_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .acc_word(acc_word), .acc_is_lit(acc_is_lit), .remap_hit(remap_hit),
        .remap_addr(remap_addr), .brk_lo(brk_lo), .brk_hi(brk_hi)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        lit;
        logic        hit;
        logic [31:0] raddr;
        logic        lo;
        logic        hi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 1'b0, 1'b1, 32'h2000_1000, 1'b0, 1'b0}, // R11 cmp0 over cmp4
        '{32'h0000_0102, 1'b0, 1'b1, 32'h2000_1000, 1'b0, 1'b0}, // R6 low bits ignored
        '{32'h0000_0200, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0}, // R9 mode1
        '{32'h0000_0300, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1}, // R9 mode2
        '{32'h0000_0400, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R9 mode3
        '{32'h0000_0500, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R6 disabled
        '{32'h0000_0600, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7 lit ignores fetch
        '{32'h0000_0600, 1'b1, 1'b1, 32'h2000_1018, 1'b0, 1'b0}, // R10 mode3 -> remap
        '{32'h0000_0100, 1'b1, 1'b1, 32'h2000_101C, 1'b0, 1'b0}, // R7 R8 cmp7
        '{32'h0000_0200, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R7 code ignores lit
        '{32'h2000_0100, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R6 high bits
        '{32'h0000_0104, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}  // R6 other word
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic acc(input logic [31:0] a, input logic lit);
        @(negedge clk);
        acc_word = a[31:2]; acc_is_lit = lit;
        #1;
    endtask

    function automatic logic [31:0] outs();
        return {28'd0, remap_hit, brk_lo, brk_hi, 1'b0};
    endfunction

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, r); chk("R1 ctrl", r, 32'h0000_0260);
        rd(4'd1, r); chk("R1 remap", r, 32'h2000_0000);
        for (int i = 2; i < 10; i++) begin
            rd(4'(i), r); chk("R1 cmp", r, 32'h0);
        end
        acc(32'h0, 1'b0); chk("R1 outputs", outs(), 32'h0);

        // R4 remap base mask
        wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, r); chk("R4 mask", r, 32'h3FFF_FFE0);
        wr(4'd1, 32'hC000_101F); rd(4'd1, r); chk("R4 base", r, 32'h2000_1000);

        // R3 read-only counts, R2 key bit reads 0
        wr(4'd0, 32'hFFFF_FFF3); rd(4'd0, r); chk("R3 R2 ctrl", r, 32'h0000_0261);

        // comparator programming, R5 readback
        wr(4'd2, 32'h0000_0101);
        wr(4'd3, 32'h4000_0201);
        wr(4'd4, 32'h8000_0301);
        wr(4'd5, 32'hC000_0401);
        wr(4'd6, 32'h4000_0101);
        wr(4'd7, 32'h0000_0500);
        wr(4'd8, 32'hC000_0601);
        wr(4'd9, 32'h0000_0101);
        rd(4'd8, r); chk("R5 cmp6", r, 32'hC000_0601);

        for (int v = 0; v < NV; v++) begin
            acc(VECS[v].addr, VECS[v].lit);
            chk($sformatf("R6-vec%0d flags", v), outs(),
                {28'd0, VECS[v].hit, VECS[v].lo, VECS[v].hi, 1'b0});
            chk($sformatf("R8 vec%0d addr", v), remap_addr, VECS[v].raddr);
        end

        // R5 full-width comparator and reserved index
        wr(4'd7, 32'hFFFF_FFFE); rd(4'd7, r); chk("R5 cmp5 full", r, 32'hFFFF_FFFE);
        wr(4'd12, 32'hFFFF_FFFF); rd(4'd12, r); chk("R5 reserved read", r, 32'h0);
        rd(4'd1, r); chk("R5 reserved write ignored", r, 32'h2000_1000);
        acc(32'h0000_0100, 1'b0); chk("R5 outputs after reserved write", outs(), 32'h8);

        // R2 unkeyed write discarded
        wr(4'd0, 32'h0000_0000); rd(4'd0, r); chk("R2 unkeyed", r, 32'h0000_0261);
        acc(32'h0000_0100, 1'b0); chk("R2 still hit", outs(), 32'h8);

        // R12 keyed disable: old value until the capturing edge
        acc(32'h0000_0100, 1'b0);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_0002;
        #1; chk("R12 before edge", outs(), 32'h8);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1; chk("R12 after edge", outs(), 32'h0);
        rd(4'd0, r); chk("R2 keyed disable", r, 32'h0000_0260);
        acc(32'h0000_0600, 1'b1); chk("R6 global off", outs(), 32'h0);

        // R11 disable cmp0: cmp4 breakpoint now decides
        wr(4'd0, 32'h0000_0003);
        wr(4'd2, 32'h0000_0100);
        acc(32'h0000_0100, 1'b0); chk("R11 cmp4 takes over", outs(), 32'h4);
        chk("R11 no remap addr", remap_addr, 32'h0);
        // R11 same word: literal load still finds cmp7
        acc(32'h0000_0100, 1'b1); chk("R11 lit cmp7", remap_addr, 32'h2000_101C);

        // R1 reset restores everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(4'd0, r); chk("R1 ctrl after reset", r, 32'h0000_0260);
        rd(4'd1, r); chk("R1 remap after reset", r, 32'h2000_0000);
        rd(4'd9, r); chk("R1 cmp7 after reset", r, 32'h0);
        acc(32'h0000_0100, 1'b1); chk("R1 outputs after reset", outs(), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule